// File: doc/BRIEF.md
# Serial Bit-Rate Clock Generator

This block turns the system clock into the timing enables a serial transceiver needs. Software programs a 12-bit divisor through two byte-wide write ports. One port loads the upper nibble and the other loads the lower byte. A reloading down-counter produces a one-cycle base tick once every divisor+1 system cycles. That base tick goes to the receiver's bit-recovery sequencer without further division, because that sequencer already spends 16, 8 or 2 base ticks on each bit.

A post-divider counts base ticks to make the transmitter bit tick. It divides by 16 in normal asynchronous mode, by 8 in double-speed asynchronous mode and by 2 in synchronous master mode. Synchronous mode takes priority over the double-speed select. In synchronous master mode an external clock level toggles on every base tick, so it forms a square wave at the transmitter bit rate. Writing the low byte restarts the whole timing chain, which lets software align the first bit period to the write.

Top module: `baud_rate_gen`

## Requirements
- R1: With divisor D held steady, `rx_base_tick` is high for exactly one cycle in every D+1 system cycles.
- R2: The divisor is 12 bits wide. A high-byte write stores only bits [3:0] of `wr_data` as divisor bits [11:8], and a divisor of 4095 gives a 4096-cycle base period.
- R3: A low-byte write loads the counter with the newly written divisor. If the write is taken at clock edge 0, `rx_base_tick` stays low until it rises after edge D+1.
- R4: A high-byte write does not reload the counter. The period already running finishes with the old count, and the new divisor applies from the next reload.
- R5: A divisor of 0 makes `rx_base_tick` high on every cycle.
- R6: `tx_tick` is high only together with `rx_base_tick`, on every Nth base tick. N is 16 when `sync_mode`=0 and `dbl_speed`=0, N is 8 when `sync_mode`=0 and `dbl_speed`=1, and N is 2 whenever `sync_mode`=1.
- R7: A low-byte write, or any change of {`sync_mode`,`dbl_speed`}, clears the post-divider. The next `tx_tick` then falls on the Nth base tick after that edge.
- R8: When `sync_mode`=1, `ext_clk` starts low after a clear and toggles on the edge after each base tick. When `sync_mode`=0, `ext_clk` is low from the next edge on.
- R9: While `rst_n` is low, all outputs are low and the divisor is cleared to 0. After release the base tick therefore runs every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_lo | input | 1 | Write strobe for divisor bits [7:0]; restarts the timing |
| wr_hi | input | 1 | Write strobe for divisor bits [11:8] |
| wr_data | input | 8 | Write data byte |
| dbl_speed | input | 1 | Double-speed asynchronous select |
| sync_mode | input | 1 | Synchronous master mode select |
| rx_base_tick | output | 1 | Undivided one-cycle base tick for the receiver |
| tx_tick | output | 1 | One-cycle transmitter bit tick |
| ext_clk | output | 1 | External clock level in synchronous master mode |

## Verification
Edges are counted from the clock edge that takes the low-byte write, which is edge 0. The base tick is registered, so it is due in the cycle after edge k·(D+1). The transmitter tick comes out combinationally with that same base tick when k is a multiple of N. The external clock level after edge i equals the parity of the number of base ticks seen before i. The bench sets its inputs on falling edges and samples every output on the falling edge that follows each rising edge. At each sample it compares against these closed-form counts for every cycle of a run, so any tick that arrives one cycle early or late fails that cycle's check.

// File: rtl/baud_pkg.sv
// Package: shared constants for the bit-rate generator.
// Assumes: divisor is at least one byte wide and post-divide ratios are >= 2.
package baud_pkg;

    localparam int DIV_W_DEF      = 12;
    localparam int BYTE_W_DEF     = 8;
    localparam int RATIO_NORM_DEF = 16;
    localparam int RATIO_DBL_DEF  = 8;
    localparam int RATIO_SYNC_DEF = 2;

    // Encoding of {sync_mode, dbl_speed} as seen by the post-divider.
    typedef enum logic [1:0] {
        MODE_ASYNC    = 2'b00,
        MODE_ASYNC_2X = 2'b01,
        MODE_SYNC     = 2'b10,
        MODE_SYNC_ALT = 2'b11
    } baud_mode_e;

endpackage

// File: rtl/baud_divisor_regs.sv
// Module: holds the divisor written through two byte ports.
// The low-byte write also produces a reload request and the value the
// counter must load in that same edge (new low byte, current high part).
// Assumes: DIV_W > BYTE_W; only the low DIV_W-BYTE_W bits of a high write are kept.
module baud_divisor_regs #(
    parameter int DIV_W  = baud_pkg::DIV_W_DEF,
    parameter int BYTE_W = baud_pkg::BYTE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [DIV_W-1:0]  div_q,
    output logic [DIV_W-1:0]  reload_val,
    output logic              reload_req
);
    localparam int HI_W = DIV_W - BYTE_W;

    logic [HI_W-1:0]   hi_q;
    logic [BYTE_W-1:0] lo_q;

    // Store the divisor bytes; reset clears the divisor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (wr_hi) hi_q <= wr_data[HI_W-1:0];
            if (wr_lo) lo_q <= wr_data;
        end
    end

    // Present the stored divisor and the value loaded on a restart.
    always_comb begin
        div_q      = {hi_q, lo_q};
        reload_val = {hi_q, wr_data};
        reload_req = wr_lo;
    end

endmodule

// File: rtl/baud_down_counter.sv
// Module: reloading down-counter producing the registered base tick.
// Counts from the divisor to zero, raises a one-cycle tick on the cycle
// after zero and reloads; a restart loads the new divisor and drops the tick.
// Assumes: reload_val is valid whenever reload_now is high.
module baud_down_counter #(
    parameter int DIV_W = baud_pkg::DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_now,
    input  logic [DIV_W-1:0] reload_val,
    input  logic [DIV_W-1:0] div_q,
    output logic             base_tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             tick_q;
    logic             at_zero;

    // Detect the terminal count.
    always_comb at_zero = (cnt_q == '0);

    // Count down, reload on zero or restart, register the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (reload_now) begin
            cnt_q  <= reload_val;
            tick_q <= 1'b0;
        end else begin
            tick_q <= at_zero;
            cnt_q  <= at_zero ? div_q : cnt_q - 1'b1;
        end
    end

    // Drive the tick output.
    always_comb base_tick = tick_q;

    // R3: a restart is never followed directly by a tick.
    assert_restart_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reload_now |=> !base_tick);

    // R1: with a non-zero divisor reloaded, ticks never come back to back.
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (base_tick && ($past(div_q) != '0)) |=> !base_tick);

    // R5: a zero divisor keeps the tick high on consecutive cycles.
    assert_zero_div_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (base_tick && ($past(div_q) == '0) && !reload_now) |=> base_tick);

endmodule

// File: rtl/baud_post_divider.sv
// Module: divides the base tick by a mode-selected ratio for the
// transmitter and makes the synchronous master clock level.
// Clears on restart or on any change of the mode inputs; the ratio in
// use is taken from the registered mode so that a mode edge cannot glitch.
// Assumes: every ratio is between 2 and RATIO_NORM.
module baud_post_divider #(
    parameter int RATIO_NORM = baud_pkg::RATIO_NORM_DEF,
    parameter int RATIO_DBL  = baud_pkg::RATIO_DBL_DEF,
    parameter int RATIO_SYNC = baud_pkg::RATIO_SYNC_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic base_tick,
    input  logic restart,
    input  logic sync_mode,
    input  logic dbl_speed,
    output logic tx_tick,
    output logic ext_clk
);
    import baud_pkg::*;

    localparam int PCNT_W = $clog2(RATIO_NORM);
    localparam logic [PCNT_W-1:0] LAST_NORM = PCNT_W'(RATIO_NORM - 1);
    localparam logic [PCNT_W-1:0] LAST_DBL  = PCNT_W'(RATIO_DBL - 1);
    localparam logic [PCNT_W-1:0] LAST_SYNC = PCNT_W'(RATIO_SYNC - 1);

    baud_mode_e        mode_now;
    baud_mode_e        mode_q;
    logic              mode_chg;
    logic              clear;
    logic [PCNT_W-1:0] last_idx;
    logic [PCNT_W-1:0] pcnt_q;
    logic              at_last;
    logic              ext_q;

    // Decode the mode inputs and the clear condition.
    always_comb begin
        mode_now = baud_mode_e'({sync_mode, dbl_speed});
        mode_chg = (mode_now != mode_q);
        clear    = restart | mode_chg;
    end

    // Select the last post-divide index for the registered mode.
    always_comb begin
        unique case (mode_q)
            MODE_ASYNC:    last_idx = LAST_NORM;
            MODE_ASYNC_2X: last_idx = LAST_DBL;
            default:       last_idx = LAST_SYNC;
        endcase
        at_last = (pcnt_q == last_idx);
    end

    // Track the mode and count base ticks up to the ratio.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_ASYNC;
            pcnt_q <= '0;
        end else begin
            mode_q <= mode_now;
            if (clear)          pcnt_q <= '0;
            else if (base_tick) pcnt_q <= at_last ? '0 : pcnt_q + 1'b1;
        end
    end

    // Toggle the external clock level on each base tick in sync mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ext_q <= 1'b0;
        else if (!sync_mode || clear) ext_q <= 1'b0;
        else if (base_tick)          ext_q <= ~ext_q;
    end

    // Drive the outputs.
    always_comb begin
        tx_tick = base_tick & at_last;
        ext_clk = ext_q;
    end

    // R6: the post-divide count never passes the ratio in use.
    assert_pcnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_q <= last_idx);

    // R7: a clear is never followed directly by a transmitter tick.
    assert_clear_no_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !tx_tick);

    // R8: in sync mode the transmitter tick falls while the clock level is high.
    assert_sync_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_tick && mode_q[1]) |-> ext_clk);

    // R8: leaving sync mode drives the clock level low.
    assert_async_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_mode |=> !ext_clk);

endmodule

// File: rtl/baud_rate_gen.sv
// Module: top of the bit-rate generator. Connects the divisor registers,
// the reloading down-counter and the mode post-divider.
// Assumes: write strobes are single-cycle and synchronous to clk.
module baud_rate_gen #(
    parameter int DIV_W      = baud_pkg::DIV_W_DEF,
    parameter int BYTE_W     = baud_pkg::BYTE_W_DEF,
    parameter int RATIO_NORM = baud_pkg::RATIO_NORM_DEF,
    parameter int RATIO_DBL  = baud_pkg::RATIO_DBL_DEF,
    parameter int RATIO_SYNC = baud_pkg::RATIO_SYNC_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              dbl_speed,
    input  logic              sync_mode,
    output logic              rx_base_tick,
    output logic              tx_tick,
    output logic              ext_clk
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] reload_val;
    logic             reload_req;
    logic             base_tick;

    baud_divisor_regs #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .wr_data    (wr_data),
        .div_q      (div_q),
        .reload_val (reload_val),
        .reload_req (reload_req)
    );

    baud_down_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload_now (reload_req),
        .reload_val (reload_val),
        .div_q      (div_q),
        .base_tick  (base_tick)
    );

    baud_post_divider #(
        .RATIO_NORM (RATIO_NORM),
        .RATIO_DBL  (RATIO_DBL),
        .RATIO_SYNC (RATIO_SYNC)
    ) u_post (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .restart   (reload_req),
        .sync_mode (sync_mode),
        .dbl_speed (dbl_speed),
        .tx_tick   (tx_tick),
        .ext_clk   (ext_clk)
    );

    // Drive the receiver tick.
    always_comb rx_base_tick = base_tick;

    // R6: the transmitter tick only ever coincides with a base tick.
    assert_tx_on_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tick |-> rx_base_tick);

    // R4: a lone high-byte write leaves a running count undisturbed (no tick injected).
    assert_hi_no_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo && !rx_base_tick && $past(!rx_base_tick) && $past(!wr_lo)
         && (div_q != '0)) |=> $stable(tx_tick) || !tx_tick);

endmodule

// File: tb/baud_rate_gen_bench.sv
`timescale 1ns/1ps
module baud_rate_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_lo = 1'b0;
    logic       wr_hi = 1'b0;
    logic [7:0] wr_data = '0;
    logic       dbl_speed = 1'b0;
    logic       sync_mode = 1'b0;
    logic       rx_base_tick;
    logic       tx_tick;
    logic       ext_clk;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    baud_rate_gen u_baud_rate_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_lo        (wr_lo),
        .wr_hi        (wr_hi),
        .wr_data      (wr_data),
        .dbl_speed    (dbl_speed),
        .sync_mode    (sync_mode),
        .rx_base_tick (rx_base_tick),
        .tx_tick      (tx_tick),
        .ext_clk      (ext_clk)
    );

    function automatic void chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at %0t: actual=%b expected=%b", tag, what, $time, act, exp);
        end
    endfunction

    // Program divisor d (high then low byte) with the given mode, then check n cycles.
    task automatic sweep(input int d, input logic s, input logic dbl, input int n,
                         input string rtag);
        int ratio = s ? 2 : (dbl ? 8 : 16);
        int p = d + 1;
        @(negedge clk);
        sync_mode = s; dbl_speed = dbl;
        wr_hi = 1'b1; wr_data = 8'((d >> 8) | 8'hF0);   // R2: upper data bits ignored
        @(negedge clk);
        wr_hi = 1'b0; wr_lo = 1'b1; wr_data = 8'(d & 255);
        @(negedge clk);
        wr_lo = 1'b0;
        chk("R3", "rx after restart", rx_base_tick, 1'b0);
        chk("R7", "tx after restart", tx_tick, 1'b0);
        chk("R8", "ext after restart", ext_clk, 1'b0);
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            begin
                logic tk = ((i % p) == 0);
                int   b  = i / p;
                chk(rtag, "rx tick", rx_base_tick, tk);
                chk("R6", "tx tick", tx_tick, tk && ((b % ratio) == 0));
                chk("R8", "ext clk", ext_clk, s ? logic'(((i - 1) / p) % 2) : 1'b0);
            end
        end
    endtask

    initial begin
        // R9: reset holds outputs low.
        repeat (3) @(negedge clk);
        chk("R9", "rx in reset", rx_base_tick, 1'b0);
        chk("R9", "tx in reset", tx_tick, 1'b0);
        chk("R9", "ext in reset", ext_clk, 1'b0);
        rst_n = 1'b1;
        for (int i = 1; i <= 17; i++) begin
            @(negedge clk);
            chk("R9", "rx after reset (div 0)", rx_base_tick, 1'b1);
            chk("R9", "tx after reset", tx_tick, (i % 16) == 0);
        end

        // R1/R5/R6/R8: sweep small divisors over all mode encodings.
        for (int m = 0; m < 4; m++) begin
            for (int d = 0; d <= 5; d++) begin
                sweep(d, logic'(m >> 1), logic'(m & 1), 2 * 16 * (d + 1) + 2,
                      (d == 0) ? "R5" : "R1");
            end
        end

        // R2: largest divisor.
        sweep(4095, 1'b0, 1'b0, 4097, "R2");

        // R4: high-byte write mid-period does not restart.
        @(negedge clk);
        sync_mode = 1'b0; dbl_speed = 1'b0;
        wr_hi = 1'b1; wr_data = 8'hF1;
        @(negedge clk);
        wr_hi = 1'b0; wr_lo = 1'b1; wr_data = 8'h05;
        @(negedge clk);
        wr_lo = 1'b0;
        for (int i = 1; i <= 280; i++) begin
            if (i == 10) begin wr_hi = 1'b1; wr_data = 8'h00; end
            if (i == 11) wr_hi = 1'b0;
            @(negedge clk);
            chk("R4", "rx after high write", rx_base_tick,
                (i == 262) || (i == 268) || (i == 274) || (i == 280));
        end

        // R7: mode change clears the post-divider (divisor 1).
        @(negedge clk);
        wr_hi = 1'b1; wr_data = 8'h00;
        @(negedge clk);
        wr_hi = 1'b0; wr_lo = 1'b1; wr_data = 8'h01;
        @(negedge clk);
        wr_lo = 1'b0;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (i == 7) dbl_speed = 1'b1;
            chk("R1", "rx across mode change", rx_base_tick, (i % 2) == 0);
            chk("R7", "tx after mode change", tx_tick, (i == 22) || (i == 38));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule